// File: doc/BRIEF.md
# Audio Serial Port Control and Status Register

This block is the single control and status word of a serial audio port, reached over a simple register bus. Software writes the word and reads it back, so the bit positions below are the programming interface. The block holds the audio core in reset until software releases it. It keeps two latched event flags, one for receive FIFO overflow and one for secondary transmit FIFO underrun. Each flag has its own interrupt enable. The block also shows the live empty and full state of the secondary transmit FIFO.

A request/acknowledge handshake feeds the secondary transmit FIFO from an external DMA controller. There are two ways to stop the request:
- Setting the pause bit stops it gracefully. A transfer that is already in flight runs until its acknowledge.
- Clearing the active bit stops it at once, even in the middle of a transfer.

The read path is combinational from the stored bits and the FIFO flags. Writes take effect on the clock edge where `reg_wr` is high.

Top module: `audio_ctl_reg`

## Requirements
- R1: After `rst_n` is low, all stored bits are 0, `core_rst_n`, `irq` and `dma_req` are 0, and `reg_rdata` shows only the live FIFO flags.
- R2: Bit 31 is the core release bit. `core_rst_n` equals the stored bit 31, and its new value appears on the edge where it is written.
- R3: Bit 26 latches a receive overflow. It is set on any edge with `rx_ovf_evt` high and stays set. Writing 1 to bit 26 clears it. Writing 0 leaves it unchanged.
- R4: When an event input and a write-one clear of the same status bit fall on the same edge, the status bit ends up 1.
- R5: Bit 24 latches a secondary transmit underrun (`txs_urun_evt`). It is set, cleared and kept in the same way as bit 26.
- R6: Bit 25 enables the overflow interrupt and bit 23 enables the underrun interrupt. `irq` is a register. It equals (bit26 AND bit25) OR (bit24 AND bit23) as that value stood one edge earlier.
- R7: Bit 22 reads `txs_empty` and bit 21 reads `txs_full`, combinationally. Writes to these two bits have no effect.
- R8: Bits 30:27, bit 19 and bits 17:0 always read 0, whatever is written.
- R9: The writable bits 31, 25, 23, 20 and 18 read back the value last written.
- R10: When no transfer is in flight, `dma_req` = bit18 AND NOT bit20 AND bit31 AND NOT `txs_full`. A transfer is in flight from an edge where `dma_req` is high and `dma_ack` is low, until an edge with `dma_ack` high.
- R11: Bit 20 is the pause bit. While a transfer is in flight, `dma_req` stays high even if pause is set or the FIFO becomes full. It drops only after the edge that samples `dma_ack`, and then stays low while pause is set.
- R12: Bit 18 is the active bit. In the cycle it reads 0, or bit 31 reads 0, `dma_req` is 0 even in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| rx_ovf_evt | input | 1 | One-cycle pulse: receive FIFO overflowed |
| txs_urun_evt | input | 1 | One-cycle pulse: secondary transmit FIFO underran |
| txs_empty | input | 1 | Secondary transmit FIFO is empty |
| txs_full | input | 1 | Secondary transmit FIFO is full |
| dma_ack | input | 1 | DMA controller accepts the current request |
| dma_req | output | 1 | DMA request to the controller |
| core_rst_n | output | 1 | Active-low reset to the audio core |
| irq | output | 1 | Interrupt request, registered |

## Verification
Results fall due at three different times:
- Stored bits, status bits and `core_rst_n` change on the edge that samples the write or the event.
- `irq` follows one edge later.
- `dma_req`, bits 22 and 21 follow their inputs within the same cycle.

The bench drives inputs on falling edges and samples on the following falling edge, so every register on the path has settled. For `irq`, it waits one more falling edge. The request gating and the interrupt combine are each swept over all sixteen combinations of their four inputs. In the gating sweep, `dma_ack` is held high so that no transfer is in flight.

// File: rtl/audio_ctl_reg.sv
module audio_ctl_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rx_ovf_evt,
  input  logic        txs_urun_evt,
  input  logic        txs_empty,
  input  logic        txs_full,
  input  logic        dma_ack,
  output logic        dma_req,
  output logic        core_rst_n,
  output logic        irq
);
  localparam int B_REL   = 31;
  localparam int B_OVF   = 26;
  localparam int B_OVFEN = 25;
  localparam int B_UR    = 24;
  localparam int B_UREN  = 23;
  localparam int B_EMPTY = 22;
  localparam int B_FULL  = 21;
  localparam int B_PAUSE = 20;
  localparam int B_ACT   = 18;

  logic rel, ovf, ovf_en, ur, ur_en, pause, act, busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel <= 1'b0; ovf_en <= 1'b0; ur_en <= 1'b0; pause <= 1'b0; act <= 1'b0;
    end else if (reg_wr) begin
      rel    <= reg_wdata[B_REL];
      ovf_en <= reg_wdata[B_OVFEN];
      ur_en  <= reg_wdata[B_UREN];
      pause  <= reg_wdata[B_PAUSE];
      act    <= reg_wdata[B_ACT];
    end
  end

  wire ovf_clr = reg_wr & reg_wdata[B_OVF];
  wire ur_clr  = reg_wr & reg_wdata[B_UR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0; ur <= 1'b0; irq <= 1'b0; busy <= 1'b0;
    end else begin
      ovf  <= rx_ovf_evt   | (ovf & ~ovf_clr);
      ur   <= txs_urun_evt | (ur  & ~ur_clr);
      irq  <= (ovf & ovf_en) | (ur & ur_en);
      busy <= dma_req & ~dma_ack;
    end
  end

  assign dma_req    = act & rel & (busy | (~pause & ~txs_full));
  assign core_rst_n = rel;

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[B_REL]   = rel;
    reg_rdata[B_OVF]   = ovf;
    reg_rdata[B_OVFEN] = ovf_en;
    reg_rdata[B_UR]    = ur;
    reg_rdata[B_UREN]  = ur_en;
    reg_rdata[B_EMPTY] = txs_empty;
    reg_rdata[B_FULL]  = txs_full;
    reg_rdata[B_PAUSE] = pause;
    reg_rdata[B_ACT]   = act;
  end

  a_r3_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[B_OVF] && !rx_ovf_evt) |=> !reg_rdata[B_OVF]);
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf_evt |=> reg_rdata[B_OVF]);
  a_r5_urun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[B_UR] && !reg_wr) |=> reg_rdata[B_UR]);
  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[B_OVFEN] && !reg_rdata[B_UREN]) |=> !irq);
  a_r11_hold_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> (dma_req || !reg_rdata[B_ACT] || !core_rst_n));
  a_r12_abort_now: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[B_ACT]) |-> !dma_req);
endmodule

// File: tb/audio_ctl_reg_test.sv
module audio_ctl_reg_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic rx_ovf_evt = 1'b0, txs_urun_evt = 1'b0, txs_empty = 1'b1, txs_full = 1'b0, dma_ack = 1'b0;
  logic dma_req, core_rst_n, irq;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  audio_ctl_reg uut (.clk, .rst_n, .reg_wr, .reg_wdata, .reg_rdata, .rx_ovf_evt, .txs_urun_evt,
                     .txs_empty, .txs_full, .dma_ack, .dma_req, .core_rst_n, .irq);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  localparam logic [31:0] REL = 32'h8000_0000, OVF = 32'h0400_0000, OVFEN = 32'h0200_0000,
    UR = 32'h0100_0000, UREN = 32'h0080_0000, PAUSE = 32'h0010_0000, ACT = 32'h0004_0000,
    RSV = 32'h7808_0000 | 32'h0003_FFFF;

  initial begin
    #100000; n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", reg_rdata, 32'h0040_0000);
    chk("R1 outs", {29'd0, core_rst_n, irq, dma_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(REL);
    chk("R2 core_rst_n", {31'd0, core_rst_n}, 32'd1);
    wr(32'hFFFF_FFFF);
    chk("R8 reserved", reg_rdata & RSV, 32'd0);
    chk("R9 readback", reg_rdata & (REL|OVFEN|UREN|PAUSE|ACT), REL|OVFEN|UREN|PAUSE|ACT);
    wr(REL);
    chk("R9 readback zero", reg_rdata & (REL|OVFEN|UREN|PAUSE|ACT), REL);

    for (int k = 0; k < 4; k++) begin
      txs_empty = k[0]; txs_full = k[1];
      wr(REL | (k[0] ? 32'h0 : 32'h0060_0000));
      chk("R7 fifo flags", {30'd0, reg_rdata[21], reg_rdata[22]}, {30'd0, k[1], k[0]});
    end
    txs_full = 1'b0; txs_empty = 1'b1;

    @(negedge clk); rx_ovf_evt = 1'b1; @(negedge clk); rx_ovf_evt = 1'b0;
    chk("R3 set", {31'd0, reg_rdata[26]}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R3 sticky", {31'd0, reg_rdata[26]}, 32'd1);
    wr(REL);
    chk("R3 write0 keeps", {31'd0, reg_rdata[26]}, 32'd1);
    wr(REL | OVF);
    chk("R3 w1c", {31'd0, reg_rdata[26]}, 32'd0);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = REL | OVF | UR; rx_ovf_evt = 1'b1; txs_urun_evt = 1'b1;
    @(negedge clk); reg_wr = 1'b0; rx_ovf_evt = 1'b0; txs_urun_evt = 1'b0;
    chk("R4 set wins", {30'd0, reg_rdata[26], reg_rdata[24]}, 32'd3);
    wr(REL);
    chk("R5 sticky", {31'd0, reg_rdata[24]}, 32'd1);
    wr(REL | UR);
    chk("R5 w1c", {31'd0, reg_rdata[24]}, 32'd0);

    for (int k = 0; k < 16; k++) begin
      wr(REL | OVF | UR | (k[1] ? OVFEN : 0) | (k[3] ? UREN : 0));
      rx_ovf_evt = k[0]; txs_urun_evt = k[2];
      @(negedge clk); rx_ovf_evt = 1'b0; txs_urun_evt = 1'b0;
      @(negedge clk);
      chk("R6 irq", {31'd0, irq}, {31'd0, (k[0] & k[1]) | (k[2] & k[3])});
    end

    dma_ack = 1'b1;
    for (int k = 0; k < 16; k++) begin
      txs_full = k[3];
      wr((k[0] ? ACT : 0) | (k[1] ? PAUSE : 0) | (k[2] ? REL : 0));
      chk("R10 gating", {31'd0, dma_req}, {31'd0, k[0] & ~k[1] & k[2] & ~k[3]});
    end
    txs_full = 1'b0; dma_ack = 1'b0;

    wr(REL | ACT);
    @(negedge clk);
    wr(REL | ACT | PAUSE);
    txs_full = 1'b1;
    chk("R11 held pause", {31'd0, dma_req}, 32'd1);
    @(negedge clk);
    chk("R11 held full", {31'd0, dma_req}, 32'd1);
    dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0; txs_full = 1'b0;
    chk("R11 drop after ack", {31'd0, dma_req}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R11 stays low", {31'd0, dma_req}, 32'd0);

    wr(REL | ACT);
    @(negedge clk);
    chk("R12 in flight", {31'd0, dma_req}, 32'd1);
    wr(REL);
    chk("R12 abort", {31'd0, dma_req}, 32'd0);
    wr(REL | ACT);
    @(negedge clk);
    wr(ACT);
    chk("R12 release off", {30'd0, core_rst_n, dma_req}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule